// File: doc/BRIEF.md
# Snooping Coherence Cache Controller

This block is the coherence agent that sits between one processor and a shared, atomic snooping bus. It holds a small direct-mapped cache in which every line is Invalid, Shared or Exclusive. The processor issues one read or write at a time. Hits complete locally. Misses and permission upgrades become bus transactions, and the block arbitrates for each one through an external request and grant pair. Requests placed on the bus by other caches arrive on a snoop port. The block compares their tags against its own lines, gives up or downgrades its copy as needed, and supplies the line when it holds it exclusively.

Each line holds one data word. Memory, the bus arbiter and the other caches live outside the block. Fill data arrives on a dedicated input once a read or read-exclusive has been issued. Transactions are atomic. The controller keeps at most one transaction open and holds the processor busy until that transaction completes.

Top module: `snoop_coh_cache`

## Requirements
- R1: After reset every line is Invalid, no bus request or bus command is driven, `cpu_busy`, `cpu_done` and `snp_supply` are low, and the first access to any address misses.
- R2: A read to a line that is not valid for its tag issues a read command (`bus_cmd` = 1) when granted. It then waits for `fill_valid`, installs the fill word as Shared, and pulses `cpu_done` one cycle later with `cpu_hit` = 0 and `cpu_rdata` equal to the fill word.
- R3: A read that hits a Shared or Exclusive line, and a write that hits an Exclusive line, create no bus request. `cpu_done` pulses in the cycle after acceptance with `cpu_hit` = 1. `cpu_rdata` carries the line's word for a read and the written word for a write.
- R4: A write to a Shared line with a matching tag issues an upgrade (`bus_cmd` = 3) with no fill phase. The line becomes Exclusive with the new word, and `cpu_done` pulses in the cycle after the grant with `cpu_hit` = 0.
- R5: A write miss issues a read-exclusive (`bus_cmd` = 2), waits for the fill, and installs the line as Exclusive holding the written word.
- R6: A snooped read-exclusive (2) or upgrade (3) whose tag matches a Shared line invalidates that line and produces no supply and no writeback.
- R7: A snooped read-exclusive whose tag matches an Exclusive line asserts `snp_supply` with the line's word in the cycle after the snoop, keeps `snp_wb` low, and leaves the line Invalid.
- R8: A snooped read (1) whose tag matches an Exclusive line asserts both `snp_supply` and `snp_wb` with the line's word in the cycle after the snoop, and leaves the line Shared.
- R9: A snooped read that matches a Shared line, and any snoop whose tag differs from the resident line, produces no response and leaves the local line unchanged.
- R10: A miss that maps onto a resident Exclusive line of another tag first issues a writeback (`bus_cmd` = 4) carrying the victim's address and word, then arbitrates again for the miss command. A resident Shared victim is dropped without any bus traffic.
- R11: Only one transaction is open at a time. `cpu_busy` stays high from acceptance until completion, `bus_req` stays high until granted, and `bus_cmd` is non-zero only in a granted cycle.
- R12: The command is chosen in the grant cycle from the line's state at that moment. A pending upgrade whose Shared copy was invalidated by a snoop is issued as a read-exclusive, and a pending writeback whose Exclusive victim was downgraded by a snoop is skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, accepted when idle and no snoop is present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_busy | output | 1 | A transaction is open; the processor must wait |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completed access hit without bus traffic |
| cpu_rdata | output | DATA_W | Read data, or write data echoed for writes |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus grant from the external arbiter |
| bus_cmd | output | 3 | 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 writeback |
| bus_addr | output | ADDR_W | Address of the issued command |
| bus_wdata | output | DATA_W | Writeback data |
| fill_valid | input | 1 | Fill word is present for an open read or read-exclusive |
| fill_data | input | DATA_W | Fill word |
| snp_valid | input | 1 | Another cache's command is on the bus |
| snp_cmd | input | 3 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | This cache supplies the snooped line |
| snp_wb | output | 1 | Supplied word must also be written to memory |
| snp_data | output | DATA_W | Supplied word |

## Verification
The bench builds the block with an 8-bit address, 8-bit data and only four lines. Addresses that differ by a multiple of four collide on purpose, so conflict eviction and the tag check in the snoop path can be reached with a handful of accesses. With the narrow data width, a memory model in the bench can seed every word from its address and expose any stale or missing writeback on a later fill. Snoops are injected while a request is waiting for its grant, which exercises the late choice of command.

// File: rtl/cc_pkg.sv
package cc_pkg;

   typedef enum logic [1:0] {
      LN_I = 2'd0,
      LN_S = 2'd1,
      LN_E = 2'd2
   } line_st_t;

   typedef enum logic [1:0] {
      CT_IDLE = 2'd0,
      CT_REQ  = 2'd1,
      CT_FILL = 2'd2
   } ctrl_st_t;

   localparam logic [2:0] BC_NONE = 3'd0;
   localparam logic [2:0] BC_RD   = 3'd1;
   localparam logic [2:0] BC_RDX  = 3'd2;
   localparam logic [2:0] BC_UPG  = 3'd3;
   localparam logic [2:0] BC_WB   = 3'd4;

endpackage

// File: rtl/cc_line_store.sv
module cc_line_store
   import cc_pkg::*;
#(
   parameter int  IDX_W    = 6,
   parameter int  TAG_W    = 10,
   parameter int  DATA_W   = 32,
   parameter bit  CLR_DATA = 1'b1,
   localparam int LINES    = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   // processor-side view
   input  logic [IDX_W-1:0]  c_idx,
   output line_st_t          c_st,
   output logic [TAG_W-1:0]  c_tag,
   output logic [DATA_W-1:0] c_data,
   // snoop-side view
   input  logic [IDX_W-1:0]  s_idx,
   output line_st_t          s_st,
   output logic [TAG_W-1:0]  s_tag,
   output logic [DATA_W-1:0] s_data,
   // own update
   input  logic              o_we,
   input  logic [IDX_W-1:0]  o_idx,
   input  line_st_t          o_st,
   input  logic [TAG_W-1:0]  o_tag,
   input  logic              o_dwe,
   input  logic [DATA_W-1:0] o_data,
   // snoop state update
   input  logic              s_we,
   input  line_st_t          s_nst
);

   logic [LINES*2-1:0]      st_flat;
   logic [LINES*TAG_W-1:0]  tag_flat;
   logic [LINES*DATA_W-1:0] dat_flat;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_st_t          st_r;
      logic [TAG_W-1:0]  tag_r;
      logic [DATA_W-1:0] dat_r;
      logic              own_sel;
      logic              snp_sel;

      assign own_sel = o_we && (o_idx == IDX_W'(g));
      assign snp_sel = s_we && (s_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n)       st_r <= LN_I;
         else if (own_sel) st_r <= o_st;
         else if (snp_sel) st_r <= s_nst;
      end

      always_ff @(posedge clk) begin
         if (own_sel) tag_r <= o_tag;
      end

      if (CLR_DATA) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)                dat_r <= '0;
            else if (own_sel && o_dwe) dat_r <= o_data;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (own_sel && o_dwe) dat_r <= o_data;
         end
      end

      assign st_flat[g*2 +: 2]           = st_r;
      assign tag_flat[g*TAG_W +: TAG_W]  = tag_r;
      assign dat_flat[g*DATA_W +: DATA_W] = dat_r;
   end

   assign c_st   = line_st_t'(st_flat[{c_idx, 1'b0} +: 2]);
   assign c_tag  = tag_flat[int'(c_idx)*TAG_W +: TAG_W];
   assign c_data = dat_flat[int'(c_idx)*DATA_W +: DATA_W];
   assign s_st   = line_st_t'(st_flat[{s_idx, 1'b0} +: 2]);
   assign s_tag  = tag_flat[int'(s_idx)*TAG_W +: TAG_W];
   assign s_data = dat_flat[int'(s_idx)*DATA_W +: DATA_W];

   // own and snoop updates never target one line in one cycle on an atomic bus
   p_no_write_clash_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(o_we && s_we && (o_idx == s_idx)));

endmodule

// File: rtl/cc_snoop.sv
module cc_snoop
   import cc_pkg::*;
#(
   parameter int TAG_W  = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic [2:0]        snp_cmd,
   input  logic [TAG_W-1:0]  q_tag,
   input  line_st_t          s_st,
   input  logic [TAG_W-1:0]  s_tag,
   input  logic [DATA_W-1:0] s_data,
   output logic              s_we,
   output line_st_t          s_nst,
   output logic              snp_supply,
   output logic              snp_wb,
   output logic [DATA_W-1:0] snp_data
);

   logic match;
   logic sup_d;
   logic wb_d;

   assign match = snp_valid && (s_st != LN_I) && (s_tag == q_tag);

   always_comb begin
      s_we  = 1'b0;
      s_nst = s_st;
      sup_d = 1'b0;
      wb_d  = 1'b0;
      if (match) begin
         unique case (s_st)
            LN_S: begin
               if (snp_cmd == BC_RDX || snp_cmd == BC_UPG) begin
                  s_we  = 1'b1;
                  s_nst = LN_I;
               end
            end
            LN_E: begin
               if (snp_cmd == BC_RD) begin
                  s_we  = 1'b1;
                  s_nst = LN_S;
                  sup_d = 1'b1;
                  wb_d  = 1'b1;
               end else if (snp_cmd == BC_RDX || snp_cmd == BC_UPG) begin
                  s_we  = 1'b1;
                  s_nst = LN_I;
                  sup_d = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snp_supply <= 1'b0;
         snp_wb     <= 1'b0;
         snp_data   <= '0;
      end else begin
         snp_supply <= sup_d;
         snp_wb     <= wb_d;
         snp_data   <= sup_d ? s_data : '0;
      end
   end

   // a memory writeback on a snoop only ever accompanies a supply (R8)
   p_wb_with_supply_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_wb |-> snp_supply);

   // a supply is always the answer to a snoop one cycle earlier (R7)
   p_supply_after_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      snp_supply |-> $past(snp_valid));

endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl
   import cc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 6,
   parameter int TAG_W  = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_busy,
   output logic              cpu_done,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              snp_valid,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [2:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data,
   // line store access
   output logic [IDX_W-1:0]  c_idx,
   input  line_st_t          c_st,
   input  logic [TAG_W-1:0]  c_tag,
   input  logic [DATA_W-1:0] c_data,
   output logic              o_we,
   output line_st_t          o_st,
   output logic [TAG_W-1:0]  o_tag,
   output logic              o_dwe,
   output logic [DATA_W-1:0] o_data
);

   ctrl_st_t          st_q;
   logic              rq_we_q;
   logic [ADDR_W-1:0] rq_addr_q;
   logic [DATA_W-1:0] rq_wdata_q;

   logic [ADDR_W-1:0] cur_addr;
   logic [TAG_W-1:0]  cur_tag;
   logic              tag_hit;
   logic              accept;
   logic              local_hit;
   logic              need_wb;
   logic [2:0]        miss_cmd;
   logic [2:0]        sel_cmd;
   logic              issue;
   logic              fill_done;
   logic              upg_done;

   assign cur_addr  = (st_q == CT_IDLE) ? cpu_addr : rq_addr_q;
   assign c_idx     = cur_addr[IDX_W-1:0];
   assign cur_tag   = cur_addr[ADDR_W-1:IDX_W];
   assign tag_hit   = (c_st != LN_I) && (c_tag == cur_tag);
   assign accept    = (st_q == CT_IDLE) && cpu_req && !snp_valid;
   assign local_hit = accept && tag_hit && (!cpu_we || c_st == LN_E);

   // decided from the line's state in the grant cycle, after any snoop
   assign need_wb   = (c_st == LN_E) && (c_tag != cur_tag);
   always_comb begin
      if (rq_we_q && tag_hit && c_st == LN_S) miss_cmd = BC_UPG;
      else if (rq_we_q)                       miss_cmd = BC_RDX;
      else                                    miss_cmd = BC_RD;
   end
   assign sel_cmd   = need_wb ? BC_WB : miss_cmd;
   assign issue     = (st_q == CT_REQ) && bus_gnt;
   assign upg_done  = issue && (sel_cmd == BC_UPG);
   assign fill_done = (st_q == CT_FILL) && fill_valid;

   assign cpu_busy  = (st_q != CT_IDLE);
   assign bus_req   = (st_q == CT_REQ);
   assign bus_cmd   = issue ? sel_cmd : BC_NONE;
   assign bus_addr  = !issue ? '0 : (need_wb ? {c_tag, c_idx} : rq_addr_q);
   assign bus_wdata = (issue && need_wb) ? c_data : '0;

   always_comb begin
      o_we   = 1'b0;
      o_st   = LN_I;
      o_tag  = cur_tag;
      o_dwe  = 1'b0;
      o_data = rq_wdata_q;
      if (local_hit && cpu_we) begin
         o_we   = 1'b1;
         o_st   = LN_E;
         o_dwe  = 1'b1;
         o_data = cpu_wdata;
      end else if (issue && need_wb) begin
         o_we   = 1'b1;
         o_st   = LN_I;
         o_tag  = c_tag;
      end else if (upg_done) begin
         o_we   = 1'b1;
         o_st   = LN_E;
         o_dwe  = 1'b1;
      end else if (fill_done) begin
         o_we   = 1'b1;
         o_st   = rq_we_q ? LN_E : LN_S;
         o_dwe  = 1'b1;
         o_data = rq_we_q ? rq_wdata_q : fill_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= CT_IDLE;
         rq_we_q    <= 1'b0;
         rq_addr_q  <= '0;
         rq_wdata_q <= '0;
      end else begin
         unique case (st_q)
            CT_IDLE: if (accept && !local_hit) begin
               st_q       <= CT_REQ;
               rq_we_q    <= cpu_we;
               rq_addr_q  <= cpu_addr;
               rq_wdata_q <= cpu_wdata;
            end
            CT_REQ: if (issue) begin
               if (need_wb)       st_q <= CT_REQ;
               else if (upg_done) st_q <= CT_IDLE;
               else               st_q <= CT_FILL;
            end
            CT_FILL: if (fill_valid) st_q <= CT_IDLE;
            default: st_q <= CT_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_done  <= 1'b0;
         cpu_hit   <= 1'b0;
         cpu_rdata <= '0;
      end else begin
         cpu_done <= local_hit || upg_done || fill_done;
         cpu_hit  <= local_hit;
         if (local_hit)      cpu_rdata <= cpu_we ? cpu_wdata : c_data;
         else if (upg_done)  cpu_rdata <= rq_wdata_q;
         else if (fill_done) cpu_rdata <= rq_we_q ? rq_wdata_q : fill_data;
         else                cpu_rdata <= '0;
      end
   end

   p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !cpu_busy);
   p_req_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> bus_req);
   p_idle_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_busy |-> !bus_req);
   p_upg_completes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == BC_UPG) |=> (cpu_done && !cpu_hit));
   p_wb_then_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == BC_WB) |=> (bus_req && !cpu_done));
   p_snoop_off_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(snp_valid && bus_req && bus_gnt));

endmodule

// File: rtl/snoop_coh_cache.sv
module snoop_coh_cache
   import cc_pkg::*;
#(
   parameter int  ADDR_W   = 16,
   parameter int  DATA_W   = 32,
   parameter int  IDX_W    = 6,
   parameter bit  CLR_DATA = 1'b1,
   localparam int TAG_W    = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_busy,
   output logic              cpu_done,
   output logic              cpu_hit,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [2:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              snp_valid,
   input  logic [2:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_supply,
   output logic              snp_wb,
   output logic [DATA_W-1:0] snp_data
);

   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("snoop_coh_cache: IDX_W must lie in 1 .. ADDR_W-1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("snoop_coh_cache: DATA_W must be positive");
   end
   if (IDX_W > 10) begin : g_bad_depth
      $error("snoop_coh_cache: IDX_W above 10 makes the line array too large");
   end

   logic [IDX_W-1:0]  c_idx;
   line_st_t          c_st;
   logic [TAG_W-1:0]  c_tag;
   logic [DATA_W-1:0] c_data;
   line_st_t          s_st;
   logic [TAG_W-1:0]  s_tag;
   logic [DATA_W-1:0] s_data;
   logic              o_we;
   line_st_t          o_st;
   logic [TAG_W-1:0]  o_tag;
   logic              o_dwe;
   logic [DATA_W-1:0] o_data;
   logic              s_we;
   line_st_t          s_nst;

   cc_line_store #(
      .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .CLR_DATA(CLR_DATA)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .c_idx(c_idx), .c_st(c_st), .c_tag(c_tag), .c_data(c_data),
      .s_idx(snp_addr[IDX_W-1:0]), .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
      .o_we(o_we), .o_idx(c_idx), .o_st(o_st), .o_tag(o_tag),
      .o_dwe(o_dwe), .o_data(o_data),
      .s_we(s_we), .s_nst(s_nst)
   );

   cc_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .clk(clk), .rst_n(rst_n),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .q_tag(snp_addr[ADDR_W-1:IDX_W]),
      .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
      .s_we(s_we), .s_nst(s_nst),
      .snp_supply(snp_supply), .snp_wb(snp_wb), .snp_data(snp_data)
   );

   cc_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
      .snp_valid(snp_valid),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .fill_valid(fill_valid), .fill_data(fill_data),
      .c_idx(c_idx), .c_st(c_st), .c_tag(c_tag), .c_data(c_data),
      .o_we(o_we), .o_st(o_st), .o_tag(o_tag), .o_dwe(o_dwe), .o_data(o_data)
   );

   // a write-back on the bus is never the final step of an access (R10)
   p_wb_not_final_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == BC_WB) |-> cpu_busy);

endmodule

// File: tb/sim_snoop_coh_cache.sv
module sim_snoop_coh_cache;
   import cc_pkg::*;

   localparam int AW = 8;
   localparam int DW = 8;

   typedef struct packed {
      logic [1:0] kind;   // 0 read, 1 write, 2 snoop
      logic [2:0] scmd;
      logic [7:0] addr;
      logic [7:0] wd;
      logic       ehit;
      logic       ewb;    // eviction writeback (cpu) or snp_wb (snoop)
      logic [2:0] ecmd;
      logic [7:0] edata;
      logic       esup;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VECS [NV] = '{
      {2'd0, 3'd0, 8'h10, 8'h00, 1'b0, 1'b0, 3'd1, 8'h4A, 1'b0},
      {2'd0, 3'd0, 8'h10, 8'h00, 1'b1, 1'b0, 3'd0, 8'h4A, 1'b0},
      {2'd1, 3'd0, 8'h10, 8'hC3, 1'b0, 1'b0, 3'd3, 8'hC3, 1'b0},
      {2'd1, 3'd0, 8'h10, 8'h77, 1'b1, 1'b0, 3'd0, 8'h77, 1'b0},
      {2'd0, 3'd0, 8'h10, 8'h00, 1'b1, 1'b0, 3'd0, 8'h77, 1'b0},
      {2'd2, 3'd1, 8'h10, 8'h00, 1'b0, 1'b1, 3'd0, 8'h77, 1'b1},
      {2'd0, 3'd0, 8'h10, 8'h00, 1'b1, 1'b0, 3'd0, 8'h77, 1'b0},
      {2'd2, 3'd1, 8'h10, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0},
      {2'd2, 3'd2, 8'h10, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0},
      {2'd0, 3'd0, 8'h10, 8'h00, 1'b0, 1'b0, 3'd1, 8'h77, 1'b0},
      {2'd1, 3'd0, 8'h21, 8'h9E, 1'b0, 1'b0, 3'd2, 8'h9E, 1'b0},
      {2'd2, 3'd1, 8'h25, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0},
      {2'd0, 3'd0, 8'h21, 8'h00, 1'b1, 1'b0, 3'd0, 8'h9E, 1'b0},
      {2'd2, 3'd2, 8'h21, 8'h00, 1'b0, 1'b0, 3'd0, 8'h9E, 1'b1},
      {2'd0, 3'd0, 8'h21, 8'h00, 1'b0, 1'b0, 3'd1, 8'h7B, 1'b0},
      {2'd1, 3'd0, 8'h22, 8'h11, 1'b0, 1'b0, 3'd2, 8'h11, 1'b0},
      {2'd0, 3'd0, 8'h26, 8'h00, 1'b0, 1'b1, 3'd1, 8'h7C, 1'b0},
      {2'd0, 3'd0, 8'h22, 8'h00, 1'b0, 1'b0, 3'd1, 8'h11, 1'b0},
      {2'd2, 3'd3, 8'h22, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0},
      {2'd0, 3'd0, 8'h22, 8'h00, 1'b0, 1'b0, 3'd1, 8'h11, 1'b0},
      {2'd1, 3'd0, 8'h03, 8'h44, 1'b0, 1'b0, 3'd2, 8'h44, 1'b0},
      {2'd2, 3'd2, 8'h07, 8'h00, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0},
      {2'd0, 3'd0, 8'h03, 8'h00, 1'b1, 1'b0, 3'd0, 8'h44, 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_busy, cpu_done, cpu_hit;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic [2:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          fill_valid = 1'b0;
   logic [DW-1:0] fill_data = '0;
   logic          snp_valid = 1'b0;
   logic [2:0]    snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_supply, snp_wb;
   logic [DW-1:0] snp_data;

   logic [7:0] mem [256];
   int checks = 0;
   int bad = 0;

   always #2 clk = ~clk;

   snoop_coh_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(2), .CLR_DATA(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .fill_valid(fill_valid), .fill_data(fill_data),
      .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_supply(snp_supply), .snp_wb(snp_wb), .snp_data(snp_data)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cpu_start(input logic we, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_req = 1'b0;
      if (!cpu_done) check(cpu_busy === 1'b1, "R11 busy while open", 32'(cpu_busy), 1);
   endtask

   task automatic cpu_finish(input logic [7:0] a, output logic hit, output logic wbs,
                             output logic [2:0] cmd, output logic [7:0] rd);
      logic [2:0] c;
      logic [7:0] ba, bd;
      hit = 1'b0; wbs = 1'b0; cmd = BC_NONE; rd = '0;
      for (int n = 0; n < 64 && !cpu_done; n++) begin
         if (bus_req) begin
            bus_gnt = 1'b1;
            #1;
            c = bus_cmd; ba = bus_addr; bd = bus_wdata;
            if (c == BC_WB) begin
               wbs = 1'b1;
               mem[ba] = bd;
            end else cmd = c;
            @(negedge clk);
            bus_gnt = 1'b0;
            if (c == BC_RD || c == BC_RDX) begin
               fill_valid = 1'b1; fill_data = mem[a];
               @(negedge clk);
               fill_valid = 1'b0;
            end
         end else @(negedge clk);
      end
      check(cpu_done === 1'b1, "R11 completion timeout", 32'(cpu_done), 1);
      hit = cpu_hit; rd = cpu_rdata;
      @(negedge clk);
   endtask

   task automatic do_snoop(input logic [2:0] c, input logic [7:0] a, output logic sup,
                           output logic wb, output logic [7:0] d);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
      @(negedge clk);
      snp_valid = 1'b0;
      sup = snp_supply; wb = snp_wb; d = snp_data;
      if (wb) mem[a] = d;
   endtask

   function automatic string tag_of(vec_t v);
      if (v.kind == 2'd2) begin
         if (v.esup) return v.ewb ? "R8" : "R7";
         return "R6 R9";
      end
      if (v.ehit)           return "R3";
      if (v.ewb)            return "R10";
      if (v.ecmd == BC_RDX) return "R5";
      if (v.ecmd == BC_UPG) return "R4";
      return "R2 R10";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      logic h, w, s;
      logic [2:0] c;
      logic [7:0] d;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      check(cpu_busy === 1'b0 && cpu_done === 1'b0, "R1 cpu idle", {cpu_busy, cpu_done}, 0);
      check(bus_req === 1'b0 && bus_cmd === 3'd0, "R1 bus idle", {bus_req, bus_cmd}, 0);
      do_snoop(BC_RDX, 8'h01, s, w, d);
      check(s === 1'b0 && w === 1'b0, "R1 empty line silent", {s, w}, 0);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string t;
         v = VECS[i];
         t = tag_of(v);
         if (v.kind == 2'd2) begin
            do_snoop(v.scmd, v.addr, s, w, d);
            check(s === v.esup, t, s, v.esup);
            check(w === v.ewb, t, w, v.ewb);
            check(d === v.edata, t, d, v.edata);
         end else begin
            cpu_start(v.kind[0], v.addr, v.wd);
            cpu_finish(v.addr, h, w, c, d);
            check(h === v.ehit, t, h, v.ehit);
            check(w === v.ewb, t, w, v.ewb);
            check(c === v.ecmd, t, c, v.ecmd);
            check(d === v.edata, t, d, v.edata);
         end
      end

      // R12: upgrade pending, Shared copy lost to a snoop -> read-exclusive
      cpu_start(1'b1, 8'h10, 8'h5F);
      do_snoop(BC_RDX, 8'h10, s, w, d);
      check(s === 1'b0, "R12 shared lost no supply", s, 0);
      cpu_finish(8'h10, h, w, c, d);
      check(c === BC_RDX, "R12 upgrade became rdx", c, BC_RDX);
      check(d === 8'h5F, "R12 write data", d, 8'h5F);
      cpu_start(1'b0, 8'h10, 8'h00);
      cpu_finish(8'h10, h, w, c, d);
      check(h === 1'b1 && d === 8'h5F, "R12 line exclusive after", {h, d}, {1'b1, 8'h5F});

      // R12: victim downgraded by a snoop while waiting -> writeback skipped
      cpu_start(1'b0, 8'h07, 8'h00);
      do_snoop(BC_RD, 8'h03, s, w, d);
      check(s === 1'b1 && w === 1'b1 && d === 8'h44, "R8 R12 downgrade supply",
            {s, w, d}, {2'b11, 8'h44});
      cpu_finish(8'h07, h, w, c, d);
      check(w === 1'b0, "R12 writeback skipped", w, 0);
      check(c === BC_RD && d === 8'h5D, "R12 read fill", {c, d}, {BC_RD, 8'h5D});
      // R10: Shared victim dropped silently, and memory holds the snoop writeback
      cpu_start(1'b0, 8'h03, 8'h00);
      cpu_finish(8'h03, h, w, c, d);
      check(w === 1'b0 && c === BC_RD, "R10 silent shared eviction", {w, c}, {1'b0, BC_RD});
      check(d === 8'h44, "R8 memory updated", d, 8'h44);

      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule